// File: doc/BRIEF.md
# Package Clock-Stop Power-State Controller

This block is the package-level power-state machine of a multi-core processor. It tracks whether the package is running normally, entering a clock stop, halted in the clock-stop grant state, servicing a snoop while halted, or asleep. It takes its inputs from the stop-clock, sleep and deep-sleep requests, from the acknowledge of the stop-grant bus cycle, from snoop detection, and from the C-state that each core reports. While the package runs normally, each core's reported state passes straight through.

A stop begins when stop-clock is held and the acknowledge input pulses. That pulse records every core's current state and starts a deadline counter. A core reporting C0 or a C1 variant must signal quiesce before the deadline expires, and it then shows the grant code. A core already in C2, C3 or C4 keeps showing that state. Once every core has reached the grant state or was already deep, the package enters the grant state. If the deadline runs out first, the remaining cores are forced into the grant state and a sticky error flag is set. The same flag records broken ordering rules on reset release and on leaving sleep.

While halted, the block latches SMI, INIT, two local interrupt lines and a monitor event, and raises a pending-break-event output. When the package returns to normal operation, each latched interrupt is replayed exactly once, and each core's recorded state is presented so the core can resume it.

Top module: `pkg_stop_ctrl`

## Requirements
- R1: While reset is high, and on the first edge after it, pkg_state is GRANT (2), pbe, err, resume and irq_fire are 0, and every core_view lane reads the grant code 6. Package state codes are: NORMAL 0, ENTER 1, GRANT 2, SNOOP 3, SLEEP 4.
- R2: In NORMAL, each 3-bit core_view lane equals the matching core_cstate lane, and the package stays in NORMAL. Core state codes are: C0 0, C1-halt 1, C1-monitor-wait 2, C2 3, C3 4, C4 5. Core 0 uses bits [2:0].
- R3: An edge with stop_req and ack both high in NORMAL moves the package to ENTER and records each core's state. A shallow core (codes 0 to 2) shows 6 from the edge at which its core_quiesce bit is seen in ENTER. The package reaches GRANT on the edge at which the last outstanding core is seen, or one edge after the ack if all cores are deep.
- R4: A core whose recorded state is 3, 4 or 5 keeps showing that code on core_view for the whole stop, whatever core_cstate does meanwhile.
- R5: If a shallow core has not quiesced by the DEADLINE-th edge after the ack edge, that edge forces GRANT, shows 6 on that core and sets err. A quiesce seen exactly on the DEADLINE-th edge sets no error.
- R6: In GRANT with sleep_req low, dropping stop_req returns the package to NORMAL on the next edge. resume then pulses for one cycle, and core_resume holds each core's recorded state.
- R7: In GRANT, snoop_hit moves the package to SNOOP. In SNOOP, snoop_done moves it back to GRANT.
- R8: In GRANT, sleep_req moves the package to SLEEP and takes priority over snoop_hit. In SLEEP, dropping sleep_req returns the package to GRANT.
- R9: In SLEEP, stop_req low sets err, whether stop_req falls before sleep_req or on the same edge.
- R10: stop_req, sleep_req or deep_req high on the last reset edge sets err on the first edge after reset is released.
- R11: In GRANT, SNOOP and SLEEP, a high smi, init_req, lint bit or mon_evt is latched, and pbe is high from the next cycle until the package returns to NORMAL. In NORMAL, these inputs latch nothing and pbe stays 0.
- R12: On the return to NORMAL, irq_fire pulses for one cycle with one bit per latched source, however often that source was raised: bit 0 smi, bit 1 init, bit 2 lint[0], bit 3 lint[1]. Pending state and pbe clear at the same edge.
- R13: err, once set, stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| stop_req | input | 1 | Stop-clock request, active high |
| sleep_req | input | 1 | Sleep request, active high |
| deep_req | input | 1 | Deep-sleep request, checked only at reset release |
| ack | input | 1 | Stop-grant acknowledge response pulse |
| snoop_hit | input | 1 | Snoop detected |
| snoop_done | input | 1 | Snoop finished |
| core_cstate | input | NCORES*3 | Per-core reported C-state codes |
| core_quiesce | input | NCORES | Per-core ready-to-stop indication |
| smi | input | 1 | System-management interrupt |
| init_req | input | 1 | INIT interrupt |
| lint | input | 2 | Local interrupt lines |
| mon_evt | input | 1 | Monitor event |
| pkg_state | output | 3 | Package state code |
| core_view | output | NCORES*3 | Effective per-core state |
| core_resume | output | NCORES*3 | Per-core state recorded at ack |
| resume | output | 1 | One-cycle pulse on return to NORMAL |
| pbe | output | 1 | Pending break event |
| irq_fire | output | 4 | One-cycle replay of latched interrupts |
| err | output | 1 | Sticky protocol error |

## Verification
The bench builds the block with two cores and a deadline of 8 edges instead of the default 20. With this shorter deadline, both the edge where quiescing is just in time and the edge where it is one too late are reached in a few cycles. Two cores are enough to mix one shallow and one deep core in a single stop, and to force one core while the other quiesces on time.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

    localparam int CSW = 3;
    localparam int NSRC = 4;

    typedef enum logic [2:0] {
        PS_NORMAL = 3'd0,
        PS_ENTER  = 3'd1,
        PS_GRANT  = 3'd2,
        PS_SNOOP  = 3'd3,
        PS_SLEEP  = 3'd4
    } pstate_e;

    localparam logic [CSW-1:0] CODE_C0    = 3'd0;
    localparam logic [CSW-1:0] CODE_C2    = 3'd3;
    localparam logic [CSW-1:0] CODE_C4    = 3'd5;
    localparam logic [CSW-1:0] CODE_GRANT = 3'd6;

    function automatic logic is_deep(input logic [CSW-1:0] c);
        return (c >= CODE_C2) && (c <= CODE_C4);
    endfunction

endpackage

// File: rtl/pcs_deadline.sv
module pcs_deadline #(
    parameter int DEADLINE = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic running,
    output logic expire
);
    localparam int CW = $clog2(DEADLINE + 1);
    localparam logic [CW-1:0] LAST = CW'(DEADLINE - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (start)
            cnt <= '0;
        else if (running && cnt != LAST)
            cnt <= cnt + 1'b1;
    end

    assign expire = running && (cnt == LAST);

    // R5: the timer never runs past the deadline window
    a_r5_window: assert property (@(posedge clk) disable iff (rst)
        running |-> (cnt <= LAST));

endmodule

// File: rtl/pcs_core_track.sv
module pcs_core_track
    import pcs_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           capture,
    input  logic           in_enter,
    input  logic           stopped,
    input  logic           force_in,
    input  logic [CSW-1:0] cstate_in,
    input  logic           quiesce,
    output logic           done_now,
    output logic [CSW-1:0] view,
    output logic [CSW-1:0] saved
);
    logic granted;
    logic done;

    always_ff @(posedge clk) begin
        if (rst) begin
            granted <= 1'b1;
            done    <= 1'b1;
            saved   <= CODE_C0;
        end else if (capture) begin
            saved   <= cstate_in;
            done    <= is_deep(cstate_in);
            granted <= 1'b0;
        end else if (in_enter && !done && (quiesce || force_in)) begin
            granted <= 1'b1;
            done    <= 1'b1;
        end
    end

    assign done_now = done || (in_enter && quiesce);

    always_comb begin
        if (!stopped)
            view = cstate_in;
        else if (granted)
            view = CODE_GRANT;
        else
            view = saved;
    end

    // R4: the recorded state cannot change while the package is stopped
    a_r4_saved_hold: assert property (@(posedge clk) disable iff (rst)
        (stopped && $past(stopped)) |-> $stable(saved));

    // R4: a deep core never shows the grant code
    a_r4_deep_shown: assert property (@(posedge clk) disable iff (rst)
        (stopped && !granted && is_deep(saved)) |-> (view != CODE_GRANT));

endmodule

// File: rtl/pcs_irq_latch.sv
module pcs_irq_latch
    import pcs_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            en,
    input  logic            flush,
    input  logic [NSRC-1:0] src,
    input  logic            mon,
    output logic            pbe,
    output logic [NSRC-1:0] fire
);
    logic [NSRC-1:0] pend;
    logic [NSRC-1:0] pend_next;
    logic            mon_p;

    assign pend_next = pend | (en ? src : '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend  <= '0;
            mon_p <= 1'b0;
            fire  <= '0;
        end else if (flush) begin
            fire  <= pend_next;
            pend  <= '0;
            mon_p <= 1'b0;
        end else begin
            fire  <= '0;
            pend  <= pend_next;
            mon_p <= mon_p | (en & mon);
        end
    end

    assign pbe = (|pend) | mon_p;

    // R12: a replay lasts exactly one cycle
    a_r12_fire_pulse: assert property (@(posedge clk) disable iff (rst)
        (|fire) |=> (fire == '0));

    // R11: a latched source stays pending until the flush
    a_r11_pend_keep: assert property (@(posedge clk) disable iff (rst)
        !flush |=> ((pend & $past(pend)) == $past(pend)));

endmodule

// File: rtl/pkg_stop_ctrl.sv
module pkg_stop_ctrl
    import pcs_pkg::*;
#(
    parameter int NCORES   = 2,
    parameter int DEADLINE = 20
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  stop_req,
    input  logic                  sleep_req,
    input  logic                  deep_req,
    input  logic                  ack,
    input  logic                  snoop_hit,
    input  logic                  snoop_done,
    input  logic [NCORES*CSW-1:0] core_cstate,
    input  logic [NCORES-1:0]     core_quiesce,
    input  logic                  smi,
    input  logic                  init_req,
    input  logic [1:0]            lint,
    input  logic                  mon_evt,
    output logic [2:0]            pkg_state,
    output logic [NCORES*CSW-1:0] core_view,
    output logic [NCORES*CSW-1:0] core_resume,
    output logic                  resume,
    output logic                  pbe,
    output logic [NSRC-1:0]       irq_fire,
    output logic                  err
);
    pstate_e state, state_n;
    logic err_set;
    logic in_rst, rst_viol;
    logic capture, in_enter, stopped, halted, expire, exit_now, all_done;
    logic [NCORES-1:0] done_vec;

    assign capture  = (state == PS_NORMAL) && stop_req && ack;
    assign in_enter = (state == PS_ENTER);
    assign stopped  = (state != PS_NORMAL);
    assign halted   = (state == PS_GRANT) || (state == PS_SNOOP) || (state == PS_SLEEP);
    assign all_done = &done_vec;

    pcs_deadline #(.DEADLINE(DEADLINE)) i_deadline (
        .clk(clk), .rst(rst), .start(capture), .running(in_enter), .expire(expire)
    );

    for (genvar g = 0; g < NCORES; g++) begin : g_core
        pcs_core_track i_track (
            .clk(clk), .rst(rst), .capture(capture), .in_enter(in_enter),
            .stopped(stopped), .force_in(expire),
            .cstate_in(core_cstate[g*CSW +: CSW]), .quiesce(core_quiesce[g]),
            .done_now(done_vec[g]), .view(core_view[g*CSW +: CSW]),
            .saved(core_resume[g*CSW +: CSW])
        );
    end

    always_comb begin
        state_n = state;
        err_set = 1'b0;
        unique case (state)
            PS_NORMAL: if (capture) state_n = PS_ENTER;
            PS_ENTER: begin
                if (!stop_req)
                    state_n = PS_NORMAL;
                else if (all_done)
                    state_n = PS_GRANT;
                else if (expire) begin
                    state_n = PS_GRANT;
                    err_set = 1'b1;
                end
            end
            PS_GRANT: begin
                if (sleep_req)
                    state_n = PS_SLEEP;
                else if (!stop_req)
                    state_n = PS_NORMAL;
                else if (snoop_hit)
                    state_n = PS_SNOOP;
            end
            PS_SNOOP: if (snoop_done) state_n = PS_GRANT;
            PS_SLEEP: begin
                if (!stop_req) err_set = 1'b1;
                if (!sleep_req) state_n = PS_GRANT;
            end
            default: state_n = PS_GRANT;
        endcase
    end

    assign exit_now = stopped && (state_n == PS_NORMAL);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= PS_GRANT;
            err      <= 1'b0;
            resume   <= 1'b0;
            in_rst   <= 1'b1;
            rst_viol <= stop_req | sleep_req | deep_req;
        end else begin
            state  <= state_n;
            resume <= exit_now;
            in_rst <= 1'b0;
            if (err_set || (in_rst && rst_viol))
                err <= 1'b1;
        end
    end

    pcs_irq_latch i_irq (
        .clk(clk), .rst(rst), .en(halted), .flush(exit_now),
        .src({lint, init_req, smi}), .mon(mon_evt), .pbe(pbe), .fire(irq_fire)
    );

    assign pkg_state = state;

    // R13: the error flag is sticky
    a_r13_err_sticky: assert property (@(posedge clk) disable iff (rst)
        err |=> err);

    // R11: nothing is pending while the package runs normally
    a_r11_pbe_normal: assert property (@(posedge clk) disable iff (rst)
        (state == PS_NORMAL) |-> !pbe);

    // R7: a finished snoop always returns to the grant state
    a_r7_snoop_back: assert property (@(posedge clk) disable iff (rst)
        (state == PS_SNOOP && snoop_done) |=> (pkg_state == 3'd2));

    // R6: a resume pulse follows only a return to normal
    a_r6_resume_normal: assert property (@(posedge clk) disable iff (rst)
        resume |-> (pkg_state == 3'd0));

endmodule

// File: tb/test_pkg_stop_ctrl.sv
module test_pkg_stop_ctrl;
    localparam int NC = 2;
    localparam int DL = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic stop_req = 0, sleep_req = 0, deep_req = 0, ack = 0;
    logic snoop_hit = 0, snoop_done = 0;
    logic [NC*3-1:0] core_cstate = '0;
    logic [NC-1:0] core_quiesce = '0;
    logic smi = 0, init_req = 0, mon_evt = 0;
    logic [1:0] lint = '0;
    logic [2:0] pkg_state;
    logic [NC*3-1:0] core_view, core_resume;
    logic resume, pbe, err;
    logic [3:0] irq_fire;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    pkg_stop_ctrl #(.NCORES(NC), .DEADLINE(DL)) i_pkg_stop_ctrl (
        .clk(clk), .rst(rst), .stop_req(stop_req), .sleep_req(sleep_req),
        .deep_req(deep_req), .ack(ack), .snoop_hit(snoop_hit),
        .snoop_done(snoop_done), .core_cstate(core_cstate),
        .core_quiesce(core_quiesce), .smi(smi), .init_req(init_req),
        .lint(lint), .mon_evt(mon_evt), .pkg_state(pkg_state),
        .core_view(core_view), .core_resume(core_resume), .resume(resume),
        .pbe(pbe), .irq_fire(irq_fire), .err(err)
    );

    // {c1, c0} inputs for the pass-through table (R2)
    localparam logic [5:0] PASS_VEC [6] = '{6'o00, 6'o01, 6'o12, 6'o35, 6'o43, 6'o54};

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        tick(); tick();
        rst = 1'b0;
        tick();
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        tick(); tick();
        // R1: reset values
        chk("R1 state", pkg_state, 2);
        chk("R1 pbe", pbe, 0);
        chk("R1 err", err, 0);
        chk("R1 view", core_view, 6'o66);
        chk("R1 fire", irq_fire, 0);
        rst = 1'b0;
        tick();
        chk("R1 state after release", pkg_state, 0);
        chk("R10 clean release err", err, 0);

        // R2: pass-through table
        foreach (PASS_VEC[i]) begin
            core_cstate = PASS_VEC[i];
            tick();
            chk("R2 view", core_view, PASS_VEC[i]);
            chk("R2 state", pkg_state, 0);
        end

        // R3/R4: core0 C1-halt, core1 C3
        core_cstate = {3'd4, 3'd1};
        stop_req = 1; ack = 1;
        tick();
        ack = 0;
        chk("R3 enter", pkg_state, 1);
        chk("R3 view recorded", core_view, 6'o41);
        tick(); tick();
        core_cstate = '0;
        tick();
        chk("R4 deep held", core_view, 6'o41);
        core_quiesce = 2'b01;
        tick();
        core_quiesce = 0;
        chk("R3 grant", pkg_state, 2);
        chk("R3 view grant", core_view, 6'o46);
        chk("R5 no err", err, 0);

        // R11: latching while halted
        smi = 1; tick(); smi = 0;
        chk("R11 pbe", pbe, 1);
        smi = 1; tick(); smi = 0;
        lint = 2'b10; tick(); lint = 0;
        // R7: snoop
        snoop_hit = 1; tick(); snoop_hit = 0;
        chk("R7 snoop", pkg_state, 3);
        tick();
        chk("R7 snoop wait", pkg_state, 3);
        snoop_done = 1; tick(); snoop_done = 0;
        chk("R7 back", pkg_state, 2);
        // R8: sleep wins over snoop
        sleep_req = 1; snoop_hit = 1; tick(); snoop_hit = 0;
        chk("R8 sleep", pkg_state, 4);
        sleep_req = 0; tick();
        chk("R8 wake", pkg_state, 2);
        chk("R9 legal order", err, 0);
        // R6/R12: exit
        stop_req = 0; tick();
        chk("R6 normal", pkg_state, 0);
        chk("R6 resume", resume, 1);
        chk("R6 resume codes", core_resume, 6'o41);
        chk("R12 fire", irq_fire, 4'b1001);
        chk("R12 pbe clear", pbe, 0);
        tick();
        chk("R12 fire once", irq_fire, 0);
        chk("R6 resume once", resume, 0);
        init_req = 1; tick(); init_req = 0; tick();
        chk("R12 normal ignores", pbe, 0);
        chk("R12 normal fire", irq_fire, 0);

        // R5: deadline miss on core0
        do_reset();
        core_cstate = '0;
        stop_req = 1; ack = 1; tick(); ack = 0;
        core_quiesce = 2'b10; tick(); core_quiesce = 0;
        repeat (DL - 2) tick();
        chk("R5 before deadline", pkg_state, 1);
        chk("R5 before deadline err", err, 0);
        tick();
        chk("R5 forced", pkg_state, 2);
        chk("R5 err", err, 1);
        chk("R5 forced view", core_view, 6'o66);
        stop_req = 0; tick();
        chk("R13 sticky", err, 1);
        chk("R13 normal", pkg_state, 0);

        // R5: quiesce exactly on the deadline edge
        do_reset();
        chk("R13 reset clears", err, 0);
        stop_req = 1; ack = 1; tick(); ack = 0;
        repeat (DL - 1) tick();
        core_quiesce = 2'b11; tick(); core_quiesce = 0;
        chk("R5 edge grant", pkg_state, 2);
        chk("R5 edge no err", err, 0);
        stop_req = 0; tick();

        // R4/R9/R11: all-deep entry, monitor, bad sleep exit
        core_cstate = {3'd5, 3'd3};
        stop_req = 1; ack = 1; tick(); ack = 0;
        chk("R3 all deep enter", pkg_state, 1);
        tick();
        chk("R3 all deep grant", pkg_state, 2);
        chk("R4 deep view", core_view, 6'o53);
        mon_evt = 1; tick(); mon_evt = 0;
        chk("R11 monitor pbe", pbe, 1);
        sleep_req = 1; tick();
        chk("R8 sleep2", pkg_state, 4);
        stop_req = 0; tick();
        chk("R9 err", err, 1);
        sleep_req = 0; tick();
        chk("R8 wake2", pkg_state, 2);
        tick();
        chk("R6 normal2", pkg_state, 0);
        chk("R12 monitor no fire", irq_fire, 0);

        // R10: stop held across reset release
        rst = 1; stop_req = 1; tick(); tick();
        rst = 0; tick();
        chk("R10 err", err, 1);
        chk("R10 stays grant", pkg_state, 2);
        stop_req = 0; tick();
        chk("R10 normal", pkg_state, 0);

        // R10: deep-sleep held across reset release
        rst = 1; deep_req = 1; tick();
        rst = 0; deep_req = 0; tick();
        chk("R10 deep err", err, 1);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule